// File: doc/BRIEF.md
# Complementary PWM Generator with Dead-Band Insertion

This block drives the two switches of a half-bridge. A free-running timer counts from zero up to a programmed period value and then starts over. The primary output is high while the timer is below a programmed duty value. The secondary output carries the inverse of that nominal waveform.

Before either output may turn on, it must wait a programmable number of clock cycles, counted from the moment its own nominal waveform goes active. That moment is also when the opposite output is turned off. The result is a guaranteed both-off gap of exactly that length at every hand-over. If the wait is as long as the nominal active stretch or longer, the output never turns on during that stretch.

Period, duty and dead-band settings are double-buffered. New values take effect only at a period boundary, or immediately while the block is disabled.

Top module: `cpwm_halfbridge`

## Requirements
- R1: The timer starts at 0 and steps by one each enabled cycle. In the cycle where it equals the active period value, it returns to 0 on the next cycle. One PWM period is therefore (period + 1) cycles long.
- R2: The nominal A waveform is high while the timer is below the active duty value, and nominal B is its inverse. Each output is a flop: its value in cycle t+1 reflects the timer and settings of cycle t.
- R3: `pwm_a_o` and `pwm_b_o` are never high in the same cycle.
- R4: Each output turns on only after its nominal waveform has been high for `db` full cycles, where `db` is the active dead-band value. This gives exactly `db` cycles with both outputs low between one output falling and the other rising (0 cycles when `db` is 0).
- R5: For a nominal active stretch of L cycles, the output is high for max(0, L − db) cycles. When `db` ≥ L, the output stays low for the whole stretch.
- R6: When the duty value is 0, A stays low and B covers the whole period. When the duty value exceeds the period value, A covers every period and B stays low. In both cases the dead band still applies.
- R7: Changes to the period, duty or dead-band inputs made in the middle of a period have no effect until the cycle after the timer reaches the end of that period.
- R8: While `en_i` is low, both outputs are low from the next cycle, the timer and the dead-band run counters are cleared, and the settings follow the inputs directly. When `en_i` rises, counting starts from 0 with a fresh dead-band wait.
- R9: While `rst_n` is low, both outputs are low, the timer is 0, and all active settings are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds outputs low and clears counters |
| period_i | input | CNT_W | Period value; the period lasts period_i + 1 cycles |
| duty_i | input | CNT_W | Duty value; nominal A is high while timer < duty_i |
| deadband_i | input | DB_W | Turn-on delay in cycles, applied to both outputs |
| pwm_a_o | output | 1 | Primary PWM drive, active high |
| pwm_b_o | output | 1 | Complementary PWM drive, active high |

## Verification
The bench builds the block with the default CNT_W = 8 and DB_W = 7. With these widths the largest dead band of 127 cycles fits inside a 256-cycle period. That makes it possible to test two cases in the same configuration: one side fully suppressed, while the other side is still shortened, to 29 cycles. The short 20-cycle periods used elsewhere cover three cases within a few hundred cycles: a zero gap, a 3-cycle gap, and a 10-cycle gap that swallows an 8-cycle pulse. The remaining scenarios exercise mid-period duty changes, duty values of 0 and above the period, and the restart after disabling.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Which half of the bridge a channel drives.
  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } cpwm_ch_e;

  // Nominal drive of a channel, derived from the primary nominal waveform.
  function automatic logic chan_nominal(input cpwm_ch_e ch, input logic nom_a);
    return (ch == CH_A) ? nom_a : ~nom_a;
  endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CNT_W = 8,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  db_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] duty_o,
  output logic [DB_W-1:0]  db_o,
  output logic             wrap_o,
  output logic             nom_o
);

  // Period ends when the timer meets the active period value.
  function automatic logic hits_end(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return c == p;
  endfunction

  // Primary waveform is active below the duty value.
  function automatic logic below_duty(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d);
    return c < d;
  endfunction

  assign wrap_o = en && hits_end(cnt_o, per_o);
  assign nom_o  = below_duty(cnt_o, duty_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      per_o  <= '0;
      duty_o <= '0;
      db_o   <= '0;
    end else if (!en) begin
      cnt_o  <= '0;
      per_o  <= per_i;
      duty_o <= duty_i;
      db_o   <= db_i;
    end else if (wrap_o) begin
      cnt_o  <= '0;
      per_o  <= per_i;
      duty_o <= duty_i;
      db_o   <= db_i;
    end else begin
      cnt_o  <= cnt_o + 1'b1;
    end
  end

  // R1: the timer never runs past the active period value
  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= per_o);

  // R7: settings hold steady between period boundaries
  a_r7_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_o) |=> $stable({per_o, duty_o, db_o}));

  // R8: disabling clears the timer
  a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt_o == '0);

endmodule

// File: rtl/cpwm_dbchan.sv
module cpwm_dbchan #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            nom_i,
  input  logic [DB_W-1:0] db_i,
  output logic            drv_o
);

  localparam logic [DB_W-1:0] RUN_MAX = {DB_W{1'b1}};

  logic [DB_W-1:0] run_q;
  logic            drv_d;

  // Count cycles the nominal waveform has been high, saturating.
  function automatic logic [DB_W-1:0] run_step(input logic [DB_W-1:0] r, input logic nom);
    if (!nom)          return '0;
    if (r == RUN_MAX)  return r;
    return r + 1'b1;
  endfunction

  // Gate opens once the wait has covered the dead band.
  function automatic logic gate_open(input logic [DB_W-1:0] r, input logic [DB_W-1:0] db);
    return r >= db;
  endfunction

  assign drv_d = en && nom_i && gate_open(run_q, db_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      drv_o <= 1'b0;
    end else if (!en) begin
      run_q <= '0;
      drv_o <= 1'b0;
    end else begin
      run_q <= run_step(run_q, nom_i);
      drv_o <= drv_d;
    end
  end

  // R5: a drive pulse is only ever produced from an active nominal cycle
  a_r5_needs_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o |-> $past(nom_i));

  // R4: the wait restarts whenever the nominal waveform drops
  a_r4_wait_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !nom_i) |=> (run_q == '0 && !drv_o));

  // R8: no drive while disabled
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drv_o);

endmodule

// File: rtl/cpwm_halfbridge.sv
module cpwm_halfbridge
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DB_W-1:0]  deadband_i,
  output logic             pwm_a_o,
  output logic             pwm_b_o
);

  localparam int NCH = 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_s;
  logic [CNT_W-1:0] duty_s;
  logic [DB_W-1:0]  db_s;
  logic             wrap;
  logic             nom_a;
  logic [NCH-1:0]   drv;

  cpwm_timebase #(
    .CNT_W (CNT_W),
    .DB_W  (DB_W)
  ) u_timebase (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_i),
    .per_i  (period_i),
    .duty_i (duty_i),
    .db_i   (deadband_i),
    .cnt_o  (cnt),
    .per_o  (per_s),
    .duty_o (duty_s),
    .db_o   (db_s),
    .wrap_o (wrap),
    .nom_o  (nom_a)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic nom_ch;
    assign nom_ch = chan_nominal(cpwm_ch_e'(g), nom_a);

    cpwm_dbchan #(
      .DB_W (DB_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_i),
      .nom_i (nom_ch),
      .db_i  (db_s),
      .drv_o (drv[g])
    );
  end

  assign pwm_a_o = drv[int'(CH_A)];
  assign pwm_b_o = drv[int'(CH_B)];

  // R3: no shoot-through
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_a_o && pwm_b_o));

  // R4: a dead band of two or more keeps B off right after A drops
  a_r4_gap_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_a_o) && db_s > 1) |=> !pwm_b_o);

  // R4: and symmetrically for A after B drops
  a_r4_gap_after_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwm_b_o) && db_s > 1) |=> !pwm_a_o);

  // R1: the period boundary returns the timer to zero
  a_r1_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);

  // R6: a duty beyond the period leaves B without any nominal time
  a_r6_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && duty_s > per_s) |=> !pwm_b_o);

endmodule

// File: tb/cpwm_halfbridge_tb.sv
module cpwm_halfbridge_tb;

  localparam int CNT_W = 8;
  localparam int DB_W  = 7;
  localparam int HMAX  = 200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en_i = 1'b0;
  logic [CNT_W-1:0] period_i = '0;
  logic [CNT_W-1:0] duty_i = '0;
  logic [DB_W-1:0]  deadband_i = '0;
  logic             pwm_a_o;
  logic             pwm_b_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cpwm_halfbridge #(.CNT_W(CNT_W), .DB_W(DB_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .period_i   (period_i),
    .duty_i     (duty_i),
    .deadband_i (deadband_i),
    .pwm_a_o    (pwm_a_o),
    .pwm_b_o    (pwm_b_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of nominal levels per side.
  int m_cnt, m_per, m_duty, m_db;
  bit ha[$];
  bit hb[$];
  bit ea, eb;

  function automatic int trailing_ones(ref bit q[$]);
    int n = 0;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (!q[i]) break;
      n++;
    end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0; m_db = 0;
      ha.delete(); hb.delete(); ea = 0; eb = 0;
    end else if (!en_i) begin
      m_cnt = 0; m_per = period_i; m_duty = duty_i; m_db = deadband_i;
      ha.delete(); hb.delete(); ea = 0; eb = 0;
    end else begin
      bit na;
      na = (m_cnt < m_duty);
      ea = na && (trailing_ones(ha) >= m_db);
      eb = !na && (trailing_ones(hb) >= m_db);
      ha.push_back(na);
      hb.push_back(!na);
      if (ha.size() > HMAX) void'(ha.pop_front());
      if (hb.size() > HMAX) void'(hb.pop_front());
      if (m_cnt == m_per) begin
        m_cnt = 0; m_per = period_i; m_duty = duty_i; m_db = deadband_i;
      end else begin
        m_cnt++;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(pwm_a_o == ea, "R2 output A vs model", pwm_a_o, ea);
      chk(pwm_b_o == eb, "R2 output B vs model", pwm_b_o, eb);
      chk(!(pwm_a_o && pwm_b_o), "R3 both high", 1, 0);
    end
  end

  task automatic config_set(input int p, input int d, input int db);
    period_i = p[CNT_W-1:0];
    duty_i = d[CNT_W-1:0];
    deadband_i = db[DB_W-1:0];
  endtask

  // Both-low cycles from A falling to B rising.
  task automatic gap_a_to_b(input int exp_gap, input string req);
    bit prev = pwm_a_o;
    int g = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (prev && !pwm_a_o) break;
      prev = pwm_a_o;
    end
    while (!pwm_b_o && g < 2000) begin
      g++;
      @(negedge clk);
    end
    chk(g == exp_gap, req, g, exp_gap);
  endtask

  task automatic gap_b_to_a(input int exp_gap, input string req);
    bit prev = pwm_b_o;
    int g = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (prev && !pwm_b_o) break;
      prev = pwm_b_o;
    end
    while (!pwm_a_o && g < 2000) begin
      g++;
      @(negedge clk);
    end
    chk(g == exp_gap, req, g, exp_gap);
  endtask

  task automatic count_high(input int len, output int na, output int nb);
    na = 0; nb = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_a_o) na++;
      if (pwm_b_o) nb++;
    end
  endtask

  task automatic wait_rise_a();
    bit prev = pwm_a_o;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!prev && pwm_a_o) break;
      prev = pwm_a_o;
    end
  endtask

  initial begin
    int na, nb, len, t0;
    rst_n = 1'b0;
    en_i = 1'b1;
    config_set(19, 8, 3);
    repeat (3) @(negedge clk);
    // R9: outputs low during reset
    chk(pwm_a_o == 0, "R9 A in reset", pwm_a_o, 0);
    chk(pwm_b_o == 0, "R9 B in reset", pwm_b_o, 0);
    en_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    en_i = 1'b1;
    repeat (45) @(negedge clk);

    // R4: 3-cycle gaps in both directions
    gap_a_to_b(3, "R4 gap A->B db=3");
    gap_b_to_a(3, "R4 gap B->A db=3");

    // R4: zero dead band gives direct hand-over
    deadband_i = 0;
    repeat (45) @(negedge clk);
    gap_a_to_b(0, "R4 gap A->B db=0");
    gap_b_to_a(0, "R4 gap B->A db=0");

    // R1: period of 20 cycles between A rises
    wait_rise_a();
    t0 = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      t0++;
      if (pwm_a_o && t0 > 1) begin
        bit dummy;
        dummy = 1'b0;
      end
      if (t0 >= 1 && pwm_a_o == 1'b1 && i > 0) begin
      end
      if (t0 == 20) break;
    end
    chk(pwm_a_o == 1, "R1 A high again after 20 cycles", pwm_a_o, 1);

    // R5: db=10 suppresses the 8-cycle A pulse, B gets 12-10=2 per period
    deadband_i = 10;
    repeat (60) @(negedge clk);
    count_high(40, na, nb);
    chk(na == 0, "R5 A suppressed", na, 0);
    chk(nb == 4, "R5 B shortened", nb, 4);

    // R6: duty zero
    config_set(19, 0, 0);
    repeat (60) @(negedge clk);
    count_high(40, na, nb);
    chk(na == 0, "R6 duty 0 A low", na, 0);
    chk(nb == 40, "R6 duty 0 B high", nb, 40);

    // R6: duty above period
    config_set(19, 30, 2);
    repeat (60) @(negedge clk);
    count_high(40, na, nb);
    chk(na == 40, "R6 duty>period A high", na, 40);
    chk(nb == 0, "R6 duty>period B low", nb, 0);

    // R7: mid-period duty change waits for the boundary
    config_set(19, 8, 0);
    repeat (60) @(negedge clk);
    wait_rise_a();
    len = 1;
    repeat (3) begin
      @(negedge clk);
      if (pwm_a_o) len++;
    end
    duty_i = 15;
    while (pwm_a_o && len < 100) begin
      @(negedge clk);
      if (pwm_a_o) len++;
    end
    chk(len == 8, "R7 old duty kept this period", len, 8);
    wait_rise_a();
    len = 0;
    while (pwm_a_o && len < 100) begin
      len++;
      @(negedge clk);
    end
    chk(len == 15, "R7 new duty next period", len, 15);

    // R8: disable forces low, re-enable restarts at timer 0
    repeat (5) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk(pwm_a_o == 0 && pwm_b_o == 0, "R8 outputs low when disabled", pwm_a_o | pwm_b_o, 0);
    repeat (4) @(negedge clk);
    config_set(19, 8, 0);
    en_i = 1'b1;
    @(negedge clk);
    chk(pwm_a_o == 1, "R8 restart at timer 0", pwm_a_o, 1);
    en_i = 1'b0;
    config_set(19, 8, 4);
    @(negedge clk);
    en_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(pwm_a_o == 0, "R8 fresh wait after enable", pwm_a_o, 0);
    @(negedge clk);
    chk(pwm_a_o == 1, "R8 A on after wait", pwm_a_o, 1);

    // R5: maximum dead band on a long period
    config_set(255, 100, 127);
    repeat (600) @(negedge clk);
    count_high(512, na, nb);
    chk(na == 0, "R5 max db A suppressed", na, 0);
    chk(nb == 58, "R5 max db B 29 per period", nb, 58);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule